// File: doc/BRIEF.md
# Packed Media Integer ALU

This block is a single-stage pipelined arithmetic unit for media kernels. It takes two packed operands, each viewed either as a row of unsigned bytes or as a row of 16-bit words, and applies one of eight lane-wise or reducing operations chosen by an opcode. The available operations are:

- a rounding average on bytes or on words;
- signed maximum and minimum on words;
- unsigned maximum and minimum on bytes;
- an unsigned word multiply that keeps the upper half of each product;
- a sum of absolute byte differences folded into one count.

A caller presents the opcode and both operands with `valid_in` high. One clock later the registered result appears with `valid_out` high. An opcode outside the defined set yields an all-zero result and raises `err_out` in the same output cycle. The unit never produces or updates a condition flag. The operand width is a parameter. A second parameter selects how the difference sum is reduced: as a linear chain or as two half sums joined at the end.

Top module: `pmalu_top`

## Requirements
- R1: Opcode 0 (byte average) returns, in each unsigned 8-bit lane, (a + b + 1) >> 1 computed without losing the carry, so 0xFF with 0xFF gives 0xFF.
- R2: Opcode 1 (word average) returns, in each unsigned 16-bit lane, (a + b + 1) >> 1 computed without losing the carry.
- R3: Opcodes 2 and 3 return the larger (2) or the smaller (3) of each pair of 16-bit two's-complement lanes.
- R4: Opcodes 4 and 5 return the larger (4) or the smaller (5) of each pair of unsigned 8-bit lanes.
- R5: Opcode 6 returns, in each 16-bit lane, bits 31:16 of the unsigned 32-bit product of the two lanes.
- R6: Opcode 7 returns the sum of the absolute differences of all byte pairs in bits 15:0, with all higher bits zero.
- R7: `result` and `valid_out` are registered exactly one clock after the `valid_in` cycle. `valid_out` is low in any cycle that follows a cycle where `valid_in` was low.
- R8: An opcode from 8 to 15 accepted with `valid_in` gives an all-zero `result` and raises `err_out` for that one output cycle only.
- R9: While `rst_n` is low, `result` is zero and both `valid_out` and `err_out` are low.
- R10: `result` holds its last value through cycles in which `valid_in` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Operands and opcode are valid this cycle |
| opcode | input | 4 | Operation select (0 to 7 defined) |
| src_a | input | DATA_W | First packed operand |
| src_b | input | DATA_W | Second packed operand |
| valid_out | output | 1 | Result register holds a new value |
| err_out | output | 1 | The accepted opcode was undefined |
| result | output | DATA_W | Registered packed result |

## Verification
The bench instantiates the unit with the default 64-bit operand width, which gives eight byte lanes and four word lanes. It also uses the linear-chain reduction. With these values a hand-checkable extreme, such as eight maximal byte differences summing to 0x7F8, lands exactly in the low field. The 64-bit width also puts both signed extremes, 0x8000 and 0x7FFF, side by side in adjacent word lanes, where a comparison of the wrong signedness is exposed. The tree reduction and other widths are covered by the elaboration-time width checks and by the bound properties, which are written in terms of the parameter.

// File: rtl/pmalu_pkg.sv
package pmalu_pkg;
   localparam int OPC_W = 4;
   typedef enum logic [OPC_W-1:0] {
      OPC_AVG_B  = 4'd0,
      OPC_AVG_W  = 4'd1,
      OPC_MAX_SW = 4'd2,
      OPC_MIN_SW = 4'd3,
      OPC_MAX_UB = 4'd4,
      OPC_MIN_UB = 4'd5,
      OPC_MULH_W = 4'd6,
      OPC_SAD_B  = 4'd7
   } pmalu_op_e;
   localparam logic [OPC_W-1:0] OPC_LAST = 4'd7;
   localparam int SAD_FIELD_W = 16;
endpackage

// File: rtl/pmalu_bytelanes.sv
module pmalu_bytelanes #(
   parameter int DATA_W = 64,
   localparam int NB = DATA_W / 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              pick_max,
   output logic [DATA_W-1:0] avg_o,
   output logic [DATA_W-1:0] ext_o
);
   for (genvar i = 0; i < NB; i++) begin : g_byte
      logic [7:0] ai, bi;
      logic [8:0] sum9;
      assign ai   = a[i*8 +: 8];
      assign bi   = b[i*8 +: 8];
      assign sum9 = {1'b0, ai} + {1'b0, bi} + 9'd1;
      assign avg_o[i*8 +: 8] = sum9[8:1];
      assign ext_o[i*8 +: 8] = ((ai > bi) == pick_max) ? ai : bi;
   end
endmodule

// File: rtl/pmalu_wordlanes.sv
module pmalu_wordlanes #(
   parameter int DATA_W = 64,
   localparam int NW = DATA_W / 16
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              pick_max,
   output logic [DATA_W-1:0] avg_o,
   output logic [DATA_W-1:0] ext_o,
   output logic [DATA_W-1:0] mulh_o
);
   for (genvar i = 0; i < NW; i++) begin : g_word
      logic [15:0] ai, bi;
      logic [16:0] sum17;
      logic [31:0] prod;
      logic        a_gt;
      assign ai    = a[i*16 +: 16];
      assign bi    = b[i*16 +: 16];
      assign sum17 = {1'b0, ai} + {1'b0, bi} + 17'd1;
      assign prod  = {16'd0, ai} * {16'd0, bi};
      assign a_gt  = $signed(ai) > $signed(bi);
      assign avg_o[i*16 +: 16]  = sum17[16:1];
      assign ext_o[i*16 +: 16]  = (a_gt == pick_max) ? ai : bi;
      assign mulh_o[i*16 +: 16] = prod[31:16];
   end
endmodule

// File: rtl/pmalu_sad.sv
module pmalu_sad #(
   parameter int DATA_W   = 64,
   parameter bit SAD_TREE = 1'b0,
   localparam int NB    = DATA_W / 8,
   localparam int SUM_W = $clog2(NB * 255 + 1)
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [SUM_W-1:0]  sum_o
);
   logic [NB-1:0][7:0] dif;

   for (genvar i = 0; i < NB; i++) begin : g_abs
      logic [7:0] ai, bi;
      assign ai     = a[i*8 +: 8];
      assign bi     = b[i*8 +: 8];
      assign dif[i] = (ai > bi) ? (ai - bi) : (bi - ai);
   end

   if (SAD_TREE) begin : g_split
      localparam int HALF = NB / 2;
      logic [SUM_W-1:0] lo_acc, hi_acc;
      always_comb begin
         lo_acc = '0;
         hi_acc = '0;
         for (int i = 0; i < HALF; i++) lo_acc = lo_acc + SUM_W'(dif[i]);
         for (int i = HALF; i < NB; i++) hi_acc = hi_acc + SUM_W'(dif[i]);
      end
      assign sum_o = lo_acc + hi_acc;
   end else begin : g_chain
      logic [SUM_W-1:0] acc;
      always_comb begin
         acc = '0;
         for (int i = 0; i < NB; i++) acc = acc + SUM_W'(dif[i]);
      end
      assign sum_o = acc;
   end
endmodule

// File: rtl/pmalu_top.sv
module pmalu_top
   import pmalu_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter bit SAD_TREE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_in,
   input  logic [3:0]        opcode,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   output logic              valid_out,
   output logic              err_out,
   output logic [DATA_W-1:0] result
);
   localparam int NB    = DATA_W / 8;
   localparam int SUM_W = $clog2(NB * 255 + 1);

   if (DATA_W < 16 || (DATA_W % 16) != 0) begin : g_bad_width
      $error("pmalu_top: DATA_W must be a positive multiple of 16");
   end
   if (SUM_W > SAD_FIELD_W) begin : g_bad_sum
      $error("pmalu_top: difference sum does not fit its 16-bit field");
   end

   logic [DATA_W-1:0] b_avg, b_ext, w_avg, w_ext, w_mulh;
   logic [SUM_W-1:0]  sad_sum;
   logic              want_max;
   logic [DATA_W-1:0] nxt_res;
   logic              nxt_err;

   assign want_max = (opcode == OPC_MAX_SW) || (opcode == OPC_MAX_UB);

   pmalu_bytelanes #(.DATA_W(DATA_W)) u_bytes (
      .a(src_a), .b(src_b), .pick_max(want_max),
      .avg_o(b_avg), .ext_o(b_ext)
   );

   pmalu_wordlanes #(.DATA_W(DATA_W)) u_words (
      .a(src_a), .b(src_b), .pick_max(want_max),
      .avg_o(w_avg), .ext_o(w_ext), .mulh_o(w_mulh)
   );

   pmalu_sad #(.DATA_W(DATA_W), .SAD_TREE(SAD_TREE)) u_sad (
      .a(src_a), .b(src_b), .sum_o(sad_sum)
   );

   always_comb begin
      nxt_err = 1'b0;
      unique case (opcode)
         OPC_AVG_B:              nxt_res = b_avg;
         OPC_AVG_W:              nxt_res = w_avg;
         OPC_MAX_SW, OPC_MIN_SW: nxt_res = w_ext;
         OPC_MAX_UB, OPC_MIN_UB: nxt_res = b_ext;
         OPC_MULH_W:             nxt_res = w_mulh;
         OPC_SAD_B:              nxt_res = DATA_W'(sad_sum);
         default: begin
            nxt_res = '0;
            nxt_err = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result    <= '0;
         valid_out <= 1'b0;
         err_out   <= 1'b0;
      end else begin
         valid_out <= valid_in;
         err_out   <= valid_in & nxt_err;
         if (valid_in) result <= nxt_res;
      end
   end
endmodule

// File: rtl/pmalu_chk.sv
module pmalu_chk
   import pmalu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              valid_in,
   input logic [3:0]        opcode,
   input logic [DATA_W-1:0] src_a,
   input logic [DATA_W-1:0] src_b,
   input logic              valid_out,
   input logic              err_out,
   input logic [DATA_W-1:0] result
);
   a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      valid_in |=> valid_out);
   a_r7_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> !valid_out);
   a_r8_bad_opcode: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && opcode > OPC_LAST) |=> (err_out && result == '0));
   a_r8_err_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      err_out |-> valid_out);
   a_r6_sad_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && opcode == OPC_SAD_B) |=> result[DATA_W-1:16] == '0);
   a_r4_umax_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && opcode == OPC_MAX_UB) |=>
         (result[7:0] >= $past(src_a[7:0]) && result[7:0] >= $past(src_b[7:0])));
   a_r3_smin_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && opcode == OPC_MIN_SW) |=>
         ($signed(result[15:0]) <= $signed($past(src_a[15:0])) &&
          $signed(result[15:0]) <= $signed($past(src_b[15:0]))));
   a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> $stable(result));
endmodule

bind pmalu_top pmalu_chk #(.DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .opcode(opcode),
   .src_a(src_a), .src_b(src_b), .valid_out(valid_out),
   .err_out(err_out), .result(result)
);

// File: tb/pmalu_top_tb_top.sv
`timescale 1ns/1ps
module pmalu_top_tb_top;
   localparam int DW = 64;
   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          valid_in = 1'b0;
   logic [3:0]    opcode = '0;
   logic [DW-1:0] src_a = '0, src_b = '0;
   logic          valid_out, err_out;
   logic [DW-1:0] result;
   int n_run = 0, n_bad = 0;

   always #10 clk = ~clk;

   pmalu_top #(.DATA_W(DW), .SAD_TREE(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .opcode(opcode),
      .src_a(src_a), .src_b(src_b), .valid_out(valid_out),
      .err_out(err_out), .result(result)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] model(input logic [3:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
      logic [DW-1:0] r = '0;
      int total = 0;
      for (int i = 0; i < DW/8; i++) begin
         int x = int'(a[i*8 +: 8]);
         int y = int'(b[i*8 +: 8]);
         if (op == 0) r[i*8 +: 8] = 8'((x + y + 1) / 2);
         if (op == 4) r[i*8 +: 8] = 8'((x > y) ? x : y);
         if (op == 5) r[i*8 +: 8] = 8'((x < y) ? x : y);
         total += (x > y) ? x - y : y - x;
      end
      for (int i = 0; i < DW/16; i++) begin
         longint ux = longint'(a[i*16 +: 16]);
         longint uy = longint'(b[i*16 +: 16]);
         int sx = int'($signed(a[i*16 +: 16]));
         int sy = int'($signed(b[i*16 +: 16]));
         if (op == 1) r[i*16 +: 16] = 16'((ux + uy + 1) / 2);
         if (op == 2) r[i*16 +: 16] = 16'((sx > sy) ? sx : sy);
         if (op == 3) r[i*16 +: 16] = 16'((sx < sy) ? sx : sy);
         if (op == 6) r[i*16 +: 16] = 16'((ux * uy) / 65536);
      end
      if (op == 7) r = DW'(total);
      return r;
   endfunction

   // drive at falling edge, registered at next rising edge, sampled at next falling edge
   task automatic issue(input logic [3:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
      @(negedge clk);
      valid_in = 1'b1; opcode = op; src_a = a; src_b = b;
      @(negedge clk);
      valid_in = 1'b0;
   endtask

   task automatic run_op(input string req, input logic [3:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
      issue(op, a, b);
      check(req, result, model(op, a, b));
      check({req, " R7 valid"}, {63'd0, valid_out}, 64'd1);
      check({req, " R8 no err"}, {63'd0, err_out}, 64'd0);
   endtask

   task automatic t_reset;
      check("R9 result", result, '0);
      check("R9 valid_out", {63'd0, valid_out}, 64'd0);
      check("R9 err_out", {63'd0, err_out}, 64'd0);
   endtask

   task automatic t_avg;
      run_op("R1 byte avg carry", 4'd0, 64'hFFFF_0001_80FE_7F00, 64'hFF00_0100_8001_8001);
      check("R1 lane FF+FF", result[63:56], 64'hFF);
      run_op("R2 word avg carry", 4'd1, 64'hFFFF_0001_8000_1234, 64'hFFFF_0000_8000_4321);
      check("R2 lane FFFF+FFFF", result[63:48], 64'hFFFF);
   endtask

   task automatic t_minmax;
      run_op("R3 signed max", 4'd2, 64'h8000_7FFF_FFFF_0005, 64'h7FFF_8000_0001_FFFB);
      check("R3 max lane3", result[63:48], 64'h7FFF);
      run_op("R3 signed min", 4'd3, 64'h8000_7FFF_FFFF_0005, 64'h7FFF_8000_0001_FFFB);
      run_op("R4 unsigned max", 4'd4, 64'h80FF_0001_7F10_AA55, 64'h7F00_FF01_8020_55AA);
      check("R4 max lane7", result[63:56], 64'h80);
      run_op("R4 unsigned min", 4'd5, 64'h80FF_0001_7F10_AA55, 64'h7F00_FF01_8020_55AA);
   endtask

   task automatic t_mul;
      run_op("R5 mul high", 4'd6, 64'hFFFF_8000_0100_1234, 64'hFFFF_0002_0100_5678);
      check("R5 FFFFxFFFF", result[63:48], 64'hFFFE);
   endtask

   task automatic t_sad;
      run_op("R6 sad max", 4'd7, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
      check("R6 sad 0x7F8", result, 64'h0000_0000_0000_07F8);
      run_op("R6 sad mixed", 4'd7, 64'h0102_0304_F0E0_1020, 64'h0403_0201_E0F0_2010);
   endtask

   task automatic t_bad_opcode;
      issue(4'd11, 64'hDEAD_BEEF_0123_4567, 64'h1111_2222_3333_4444);
      check("R8 zero result", result, '0);
      check("R8 err raised", {63'd0, err_out}, 64'd1);
      @(negedge clk);
      check("R8 err one cycle", {63'd0, err_out}, 64'd0);
   endtask

   task automatic t_idle_hold;
      logic [DW-1:0] keep;
      issue(4'd4, 64'h1122_3344_5566_7788, 64'h8877_6655_4433_2211);
      keep = result;
      @(negedge clk);
      src_a = '1; src_b = '1; opcode = 4'd0;
      @(negedge clk);
      check("R10 result held", result, keep);
      check("R7 idle valid low", {63'd0, valid_out}, 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_run++; n_bad++;
      $display("FAIL R7 watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_avg();
      t_minmax();
      t_mul();
      t_sad();
      t_bad_opcode();
      t_idle_hold();
      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule